// File: doc/BRIEF.md
# Edge-Triggered Window Watchdog

This block watches a service signal from a host processor and raises a timed reset when the host misbehaves. Time is split into repeating periods. Each period starts with a closed window, in which servicing is forbidden, and ends with an open window, in which the host must service. A service is a low-to-high transition on the trigger input. A service inside the open window starts a fresh period. An edge that arrives too early, or an open window that runs out with no edge, counts as a window error. Either error produces one reset pulse of fixed length.

The trigger input is asynchronous. It passes through a two-stage synchroniser and then an edge detector. The closed length, the open length and the pulse width are parameters counted in clock cycles. After a pulse the watchdog begins a new period at the start of its closed window. A small cause output tells software which kind of error produced the most recent reset.

Top module: `window_wdog`

## Requirements
- R1: Only a low-to-high transition of `wd_trig_i` is a service event. A level held high counts once, and holding it high through a whole open window does not service the watchdog.
- R2: A trigger level first sampled high at clock edge t is acted on at clock edge t+2.
- R3: Let S be the period's first clock edge. This is the first edge with `rst` low after reset, the edge after a valid service, or the edge after a pulse ends. An edge acted on at S+m with CLOSED_CYC <= m < CLOSED_CYC+OPEN_CYC is valid. It raises no reset, and the next period starts at S+m+1.
- R4: An edge acted on at S+m with m < CLOSED_CYC is an early error. `wd_rst_o` rises after edge S+m and `wd_cause_o` becomes 2'b01.
- R5: If no edge is acted on up to and including S+CLOSED_CYC+OPEN_CYC-1, a missing-service error occurs. `wd_rst_o` rises after that edge and `wd_cause_o` becomes 2'b10.
- R6: `wd_rst_o` stays high for exactly PULSE_CYC cycles. The edge after it falls is the start S of a new period.
- R7: Trigger edges acted on while `wd_rst_o` is high change neither the pulse length nor `wd_cause_o`.
- R8: `wd_cause_o` keeps its value until the next error. Synchronous reset `rst` clears `wd_cause_o` to 2'b00 and drives `wd_rst_o` low, and the first edge after `rst` is released starts a period. Code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_trig_i | input | 1 | Asynchronous service input; rising edges service the watchdog |
| wd_rst_o | output | 1 | Reset pulse, high for PULSE_CYC cycles after a window error |
| wd_cause_o | output | 2 | Last error cause: 00 none, 01 early, 10 missing |

## Verification
The assertions check every cycle that the edge detector never flags two cycles in a row. They also check that a closed-window edge always starts a pulse tagged early, that an expired open window always starts a pulse tagged missing, that a valid service never starts a pulse, that edges during a pulse leave it and the cause untouched, and that the counter stays inside the limit of its phase. The exact two-cycle latency of the synchroniser and the precise start and length of each pulse can only be shown by the bench. The same holds for the boundaries at the last closed cycle and at the first and last open cycles, for the held-high level that must not count as a service, and for recovery after a reset issued in the middle of a pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    PH_CLOSED = 2'b00,
    PH_OPEN   = 2'b01,
    PH_PULSE  = 2'b10
  } wdog_phase_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EARLY = 2'b01,
    CAUSE_LATE  = 2'b10
  } wdog_cause_e;

endpackage

// File: rtl/wdog_trig_sync.sv
module wdog_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= trig_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], trig_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;

  // A level change yields a single-cycle edge flag
  assert_single_rise_R1: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/wdog_cycle_ctr.sv
module wdog_cycle_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic [CW-1:0] last_i,
  output logic          at_last_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign at_last_o = (cnt_q == last_i);

  // The count never runs past the limit of the current phase
  assert_ctr_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_i);

endmodule

// File: rtl/wdog_window_fsm.sv
module wdog_window_fsm
  import wdog_pkg::*;
#(
  parameter int CLOSED_CYC = 16,
  parameter int OPEN_CYC   = 16,
  parameter int PULSE_CYC  = 8,
  parameter int CW         = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic          at_last_i,
  output logic          clr_o,
  output logic [CW-1:0] last_o,
  output logic          wd_rst_o,
  output logic [1:0]    cause_o
);

  localparam logic [CW-1:0] CLOSED_LAST = CW'(CLOSED_CYC - 1);
  localparam logic [CW-1:0] OPEN_LAST   = CW'(OPEN_CYC - 1);
  localparam logic [CW-1:0] PULSE_LAST  = CW'(PULSE_CYC - 1);

  wdog_phase_e phase_q, phase_d;
  wdog_cause_e cause_q, cause_d;
  logic        pulse_q;

  always_comb begin
    unique case (phase_q)
      PH_CLOSED: last_o = CLOSED_LAST;
      PH_OPEN:   last_o = OPEN_LAST;
      default:   last_o = PULSE_LAST;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    cause_d = cause_q;
    clr_o   = 1'b0;
    unique case (phase_q)
      PH_CLOSED: begin
        if (rise_i) begin
          phase_d = PH_PULSE;
          cause_d = CAUSE_EARLY;
          clr_o   = 1'b1;
        end else if (at_last_i) begin
          phase_d = PH_OPEN;
          clr_o   = 1'b1;
        end
      end
      PH_OPEN: begin
        if (rise_i) begin
          phase_d = PH_CLOSED;
          clr_o   = 1'b1;
        end else if (at_last_i) begin
          phase_d = PH_PULSE;
          cause_d = CAUSE_LATE;
          clr_o   = 1'b1;
        end
      end
      default: begin
        if (at_last_i) begin
          phase_d = PH_CLOSED;
          clr_o   = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CLOSED;
      cause_q <= CAUSE_NONE;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cause_q <= cause_d;
      pulse_q <= (phase_d == PH_PULSE);
    end
  end

  assign wd_rst_o = pulse_q;
  assign cause_o  = cause_q;

  assert_early_err_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CLOSED && rise_i) |=> (wd_rst_o && cause_o == 2'b01));

  assert_missing_err_R5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OPEN && !rise_i && at_last_i) |=> (wd_rst_o && cause_o == 2'b10));

  assert_valid_service_R3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_OPEN && rise_i) |=> !wd_rst_o);

  assert_pulse_ignores_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PULSE && rise_i && !at_last_i) |=> (wd_rst_o && $stable(cause_o)));

  assert_cause_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$rose(wd_rst_o)) |-> $stable(cause_o));

endmodule

// File: rtl/window_wdog.sv
module window_wdog #(
  parameter int CLOSED_CYC  = 4000,
  parameter int OPEN_CYC    = 4000,
  parameter int PULSE_CYC   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wd_trig_i,
  output logic       wd_rst_o,
  output logic [1:0] wd_cause_o
);

  localparam int MAX_A = (CLOSED_CYC > OPEN_CYC) ? CLOSED_CYC : OPEN_CYC;
  localparam int MAX_V = (MAX_A > PULSE_CYC) ? MAX_A : PULSE_CYC;
  localparam int CW    = $clog2(MAX_V + 1);

  logic          rise;
  logic          clr;
  logic          at_last;
  logic [CW-1:0] last_val;

  wdog_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .trig_i (wd_trig_i),
    .rise_o (rise)
  );

  wdog_cycle_ctr #(.CW(CW)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr),
    .last_i    (last_val),
    .at_last_o (at_last)
  );

  wdog_window_fsm #(
    .CLOSED_CYC (CLOSED_CYC),
    .OPEN_CYC   (OPEN_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .CW         (CW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .at_last_i (at_last),
    .clr_o     (clr),
    .last_o    (last_val),
    .wd_rst_o  (wd_rst_o),
    .cause_o   (wd_cause_o)
  );

  assert_cause_code_R8: assert property (@(posedge clk) disable iff (rst)
    wd_cause_o != 2'b11);

endmodule

// File: tb/window_wdog_tb.sv
module window_wdog_tb;

  localparam int C = 8;
  localparam int O = 8;
  localparam int P = 6;
  localparam int K_VALID = 0;
  localparam int K_EARLY = 1;
  localparam int K_MISS  = 2;
  localparam int NV = 10;

  // first-edge offset, kind, second-edge offset (0 = none)
  localparam int VEC_K   [NV] = '{6, 13, 9, 5, 1, -10, 10, 2, 7, -10};
  localparam int VEC_KIND[NV] = '{K_VALID, K_VALID, K_VALID, K_EARLY, K_EARLY,
                                  K_MISS, K_VALID, K_EARLY, K_VALID, K_MISS};
  localparam int VEC_K2  [NV] = '{0, 0, 0, 0, 0, 0, 0, 6, 0, 0};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       trig = 1'b0;
  logic       wd_rst;
  logic [1:0] cause;

  int checks = 0;
  int failures = 0;
  logic [1:0] exp_cause = 2'b00;
  bit done = 1'b0;

  always #5 clk = ~clk;

  window_wdog #(.CLOSED_CYC(C), .OPEN_CYC(O), .PULSE_CYC(P)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .wd_trig_i  (trig),
    .wd_rst_o   (wd_rst),
    .wd_cause_o (cause)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered at the falling edge before period start S; leaves at the falling edge before the next S.
  task automatic run_vec(input int k, input int kind, input int k2, input bit hold, input string req);
    int m, ps, n_end, bad, bad_n;
    m = k + 2;
    bad = 0;
    bad_n = -99;
    if (kind == K_MISS) begin
      ps = C + O - 1; n_end = ps + P;
    end else if (kind == K_EARLY) begin
      ps = m; n_end = m + P;
    end else begin
      ps = -100; n_end = m;
    end
    for (int n = -1; n <= n_end; n++) begin
      if (kind != K_MISS && n == k - 1) trig = 1'b1;
      if (!hold && n == k + 2) trig = 1'b0;
      if (k2 > 0 && n == k2 - 1) trig = 1'b1;
      if (k2 > 0 && n == k2 + 2) trig = 1'b0;
      if (wd_rst !== (ps >= 0 && n >= ps && n <= ps + P - 1)) begin
        bad++;
        if (bad_n == -99) bad_n = n;
      end
      if (n < n_end) @(negedge clk);
    end
    if (kind == K_EARLY) exp_cause = 2'b01;
    if (kind == K_MISS)  exp_cause = 2'b10;
    check(bad == 0, {req, " reset-pulse profile (first mismatch offset as actual)"}, bad_n, -99);
    check(cause === exp_cause, {req, " cause"}, int'(cause), int'(exp_cause));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog timeout actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wd_rst === 1'b0, "R8 reset output low", int'(wd_rst), 0);
    check(cause === 2'b00, "R8 reset cause 00", int'(cause), 0);
    rst = 1'b0;

    // table walk: R2/R3 valid, R4/R6 early, R5/R6 missing, R7 edge in pulse
    for (int i = 0; i < NV; i++) begin
      string tag;
      case (VEC_KIND[i])
        K_VALID: tag = "R2/R3";
        K_EARLY: tag = (VEC_K2[i] > 0) ? "R7" : "R4/R6";
        default: tag = "R5/R6";
      endcase
      run_vec(VEC_K[i], VEC_KIND[i], VEC_K2[i], 1'b0, tag);
    end

    // R1: level held high after a valid service does not service the next period
    run_vec(6, K_VALID, 0, 1'b1, "R1 held edge");
    run_vec(-10, K_MISS, 0, 1'b0, "R1 held level");
    trig = 1'b0;
    run_vec(8, K_VALID, 0, 1'b0, "R3 after held level");

    // R8: reset in the middle of a pulse
    @(negedge clk);            // n = 0
    trig = 1'b1;
    repeat (3) @(negedge clk); // n = 3, pulse active
    trig = 1'b0;
    check(wd_rst === 1'b1, "R4 pulse before mid-pulse reset", int'(wd_rst), 1);
    repeat (2) @(negedge clk); // n = 5
    rst = 1'b1;
    @(negedge clk);
    check(wd_rst === 1'b0, "R8 mid-pulse reset output", int'(wd_rst), 0);
    check(cause === 2'b00, "R8 mid-pulse reset cause", int'(cause), 0);
    exp_cause = 2'b00;
    rst = 1'b0;
    run_vec(6, K_VALID, 0, 1'b0, "R8 restart after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule